// File: doc/BRIEF.md
# Serial Display Byte Transmitter

This block sends one byte at a time to a small display driver over a write-only serial link. A host presents a byte together with a flag that marks it as a command or as display data, and pulses a write strobe. The block then lowers the active-low chip enable and runs eight serial clock periods, most significant bit first. The serial clock is the system clock divided by an even parameter. An address line carries the command/data flag for the whole byte.

Display drivers expect data to be launched on one of two edges. A mode input chooses which edge. In the default convention (mode 0) data changes on the falling serial clock edge. In the alternate convention (mode 1) every data change is delayed by half a serial clock period, so data changes on the rising edge. A serial-select input hands the pins to this block only when it is 1. When it is 0, a parallel display path owns the display: all outputs sit at their idle levels and writes are dropped.

Top module: `serdisp_shifter`

## Requirements
- R1: After reset the outputs are at idle levels: serial clock 0, chip enable 1, serial data 0, address 0, busy 0.
- R2: A write strobe seen while serial-select is 1 and busy is 0 is accepted. In the next cycle busy is 1 and chip enable is 0.
- R3: A frame is 17 half-periods long, each DIV/2 system cycles. The serial clock starts low and is high in odd half-periods, which gives 8 rising edges. The first rising edge comes one half-period after chip enable falls. Chip enable rises one half-period after the last falling edge.
- R4: Bits leave most significant first. In mode 0, bit 7-i is on the data line in half-periods 2i and 2i+1, so data changes only on falling serial clock edges. Half-period 16 keeps bit 0.
- R5: In mode 1, bit 7-i is on the data line in half-periods 2i+1 and 2i+2, so data changes only on rising serial clock edges. Half-period 0 shows bit 7.
- R6: The address line equals the command/data flag captured at acceptance and is stable for the whole frame. It is 0 when idle.
- R7: Write strobes while busy is 1 are ignored and do not change the frame in progress.
- R8: The mode is captured at acceptance. Changing the mode input during a frame has no effect on that frame.
- R9: While serial-select is 0, all outputs stay idle and writes are ignored. Dropping serial-select mid-frame returns every output to idle in the next cycle.
- R10: Busy falls in the same cycle that chip enable rises. The serial data line returns to 0, and a new write is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | 1 gives the pins to the serial path, 0 to the parallel path |
| edge_mode | input | 1 | 0: launch on falling edge, 1: launch on rising edge |
| wr_en | input | 1 | Write strobe, one system cycle |
| wr_data | input | 8 | Byte to send |
| wr_cmd | input | 1 | Command/data flag driven onto the address line |
| busy | output | 1 | High from accepted write until chip enable is released |
| sd_data | output | 1 | Serial data |
| sd_clk | output | 1 | Serial clock, idle low |
| sd_cs_n | output | 1 | Chip enable, active low |
| sd_addr | output | 1 | Command/data address line |

## Verification
The hardest situations to reach are the ones that disturb a frame already running: a write strobe held through the busy window, and a mode flip halfway through a byte. Neither may alter the waveform. The sweep sends every byte value in both modes. On a rotating subset it keeps the write strobe high with inverted data for the whole frame, or toggles the mode input early in the frame. It checks every system cycle of each frame against the waveform computed from the half-period index. A separate sequence drops serial-select partway through a frame and then sends a clean frame.

// File: rtl/serdisp_pkg.sv
package serdisp_pkg;
  localparam int BYTE_W = 8;
  localparam int HALVES = 2 * BYTE_W + 1;
  localparam int PH_W   = $clog2(HALVES);

  typedef enum logic {ST_IDLE, ST_SHIFT} seq_st_e;
endpackage

// File: rtl/serdisp_tick.sv
module serdisp_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  output logic tick
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || run;
    cnt_d  = cnt_q;
    if (start)
      cnt_d = '0;
    else if (cnt_q == CNT_LAST)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && !start && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/serdisp_seq.sv
module serdisp_seq
  import serdisp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick,
  input  logic mode_q,
  output logic active,
  output logic done,
  output logic shift_en,
  output logic sclk,
  output logic cs_n
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALVES - 1);

  seq_st_e         st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d, ph_nx;
  logic            sclk_q, sclk_d;
  logic            csn_q, csn_d;
  logic            step, last;
  logic            sh_m0, sh_m1;

  always_comb begin
    step  = (st_q == ST_SHIFT) && tick && !abort && !start;
    last  = (ph_q == PH_LAST);
    ph_nx = ph_q + 1'b1;
    sh_m0 = !ph_nx[0] && (ph_nx >= PH_W'(2)) && (ph_nx <= PH_W'(2 * BYTE_W - 2));
    sh_m1 =  ph_nx[0] && (ph_nx >= PH_W'(3)) && (ph_nx <= PH_W'(2 * BYTE_W - 1));
    shift_en = step && !last && (mode_q ? sh_m1 : sh_m0);
    done     = step && last;

    st_d   = st_q;
    ph_d   = ph_q;
    sclk_d = sclk_q;
    csn_d  = csn_q;
    if (abort || done) begin
      st_d   = ST_IDLE;
      ph_d   = '0;
      sclk_d = 1'b0;
      csn_d  = 1'b1;
    end else if (start) begin
      st_d   = ST_SHIFT;
      ph_d   = '0;
      sclk_d = 1'b0;
      csn_d  = 1'b0;
    end else if (step) begin
      ph_d   = ph_nx;
      sclk_d = ph_nx[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
      csn_q  <= csn_d;
    end
  end

  assign active = (st_q == ST_SHIFT);
  assign sclk   = sclk_q;
  assign cs_n   = csn_q;
endmodule

// File: rtl/serdisp_shift.sv
module serdisp_shift
  import serdisp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] din,
  input  logic              cmd,
  input  logic              mode_in,
  output logic              sdo,
  output logic              addr,
  output logic              mode_q
);
  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic              addr_q, addr_d;
  logic              mode_r, mode_d;

  always_comb begin
    sreg_d = sreg_q;
    addr_d = addr_q;
    mode_d = mode_r;
    if (clear) begin
      sreg_d = '0;
      addr_d = 1'b0;
      mode_d = 1'b0;
    end else if (load) begin
      sreg_d = din;
      addr_d = cmd;
      mode_d = mode_in;
    end else if (shift_en) begin
      sreg_d = {sreg_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      addr_q <= 1'b0;
      mode_r <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      addr_q <= addr_d;
      mode_r <= mode_d;
    end
  end

  assign sdo    = sreg_q[BYTE_W-1];
  assign addr   = addr_q;
  assign mode_q = mode_r;
endmodule

// File: rtl/serdisp_shifter.sv
module serdisp_shifter
  import serdisp_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel,
  input  logic              edge_mode,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_cmd,
  output logic              busy,
  output logic              sd_data,
  output logic              sd_clk,
  output logic              sd_cs_n,
  output logic              sd_addr
);
  localparam int HALF = (DIV < 2) ? 1 : DIV / 2;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       active, done, shift_en, tick;
  logic       accept, abort;
  logic       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign abort  = !ser_sel;
  assign accept = wr_en && ser_sel && !active;

  serdisp_tick #(.HALF(HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (active),
    .start (accept),
    .tick  (tick)
  );

  serdisp_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (accept),
    .abort    (abort),
    .tick     (tick),
    .mode_q   (mode_q),
    .active   (active),
    .done     (done),
    .shift_en (shift_en),
    .sclk     (sd_clk),
    .cs_n     (sd_cs_n)
  );

  serdisp_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (accept),
    .clear    (abort || done),
    .shift_en (shift_en),
    .din      (wr_data),
    .cmd      (wr_cmd),
    .mode_in  (edge_mode),
    .sdo      (sd_data),
    .addr     (sd_addr),
    .mode_q   (mode_q)
  );

  assign busy = active;
endmodule

// File: rtl/serdisp_checker.sv
module serdisp_checker (
  input logic clk,
  input logic rst_n,
  input logic ser_sel,
  input logic wr_en,
  input logic busy,
  input logic sd_data,
  input logic sd_clk,
  input logic sd_cs_n,
  input logic sd_addr,
  input logic mode_q
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ser_sel && !busy) |=> (busy && !sd_cs_n));

  assert_clk_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cs_n |-> !sd_clk);

  assert_cs_fall_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cs_n) |-> !sd_clk);

  assert_mode0_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && $past(!sd_cs_n) && !mode_q && !$stable(sd_data)) |-> $fell(sd_clk));

  assert_mode1_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && $past(!sd_cs_n) && mode_q && !$stable(sd_data)) |-> $rose(sd_clk));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && $past(!sd_cs_n)) |-> $stable(sd_addr));

  assert_parallel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_sel |=> (sd_cs_n && !sd_clk && !busy && !sd_data && !sd_addr));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cs_n) |-> (!busy && !sd_data));
endmodule

bind serdisp_shifter serdisp_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ser_sel (ser_sel),
  .wr_en   (wr_en),
  .busy    (busy),
  .sd_data (sd_data),
  .sd_clk  (sd_clk),
  .sd_cs_n (sd_cs_n),
  .sd_addr (sd_addr),
  .mode_q  (mode_q)
);

// File: tb/tb_serdisp_shifter.sv
`timescale 1ns/1ps
module tb_serdisp_shifter;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int FRAME = 17 * HALF;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_sel, edge_mode, wr_en, wr_cmd;
  logic [7:0] wr_data;
  logic       busy, sd_data, sd_clk, sd_cs_n, sd_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serdisp_shifter #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .edge_mode(edge_mode),
    .wr_en(wr_en), .wr_data(wr_data), .wr_cmd(wr_cmd), .busy(busy),
    .sd_data(sd_data), .sd_clk(sd_clk), .sd_cs_n(sd_cs_n), .sd_addr(sd_addr)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "sd_clk", sd_clk, 1'b0);
    chk(tag, "sd_cs_n", sd_cs_n, 1'b1);
    chk(tag, "sd_data", sd_data, 1'b0);
    chk(tag, "sd_addr", sd_addr, 1'b0);
    chk(tag, "busy", busy, 1'b0);
  endtask

  // disturb: 0 none, 1 write strobe held during busy (R7), 2 mode flipped mid-frame (R8)
  task automatic run_frame(input logic [7:0] b, input logic f, input logic m, input int disturb);
    string dtag;
    dtag = (disturb == 1) ? "R7" : (disturb == 2) ? "R8" : (m ? "R5" : "R4");
    @(negedge clk);
    edge_mode = m; wr_data = b; wr_cmd = f; wr_en = 1'b1;
    for (int j = 0; j < FRAME; j++) begin
      int k, idx;
      @(negedge clk);
      if (j == 0) begin
        if (disturb == 1) begin wr_data = ~b; wr_cmd = ~f; end
        else wr_en = 1'b0;
      end
      if (disturb == 1 && j == FRAME - 1) wr_en = 1'b0;
      if (disturb == 2 && j == 2) edge_mode = ~m;
      k = j / HALF;
      if (m) idx = (k == 0) ? 0 : (k - 1) / 2;
      else   idx = (k / 2 > 7) ? 7 : k / 2;
      chk("R2", "busy", busy, 1'b1);
      chk("R3", "sd_cs_n", sd_cs_n, 1'b0);
      chk("R3", "sd_clk", sd_clk, logic'(k % 2));
      chk(dtag, "sd_data", sd_data, b[7 - idx]);
      chk("R6", "sd_addr", sd_addr, f);
    end
    @(negedge clk);
    wr_en = 1'b0; edge_mode = m;
    chk_idle("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ser_sel = 1'b0; edge_mode = 1'b0; wr_en = 1'b0;
    wr_cmd = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1");

    // R9: parallel path selected, writes dropped
    wr_en = 1'b1; wr_data = 8'hA5; wr_cmd = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk_idle("R9");
    end
    wr_en = 1'b0;
    ser_sel = 1'b1;

    // R4/R5/R6/R7/R8: every byte in both modes
    for (int b = 0; b < 256; b++) begin
      for (int m = 0; m < 2; m++) begin
        int d;
        d = (b % 3 == 1) ? 1 : ((b % 3 == 2 && m == 1) ? 2 : 0);
        run_frame(8'(b), logic'(b % 2) ^ logic'(m), logic'(m), d);
      end
    end

    // R9: drop serial-select mid-frame
    @(negedge clk);
    wr_data = 8'hFF; wr_cmd = 1'b1; edge_mode = 1'b0; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9", "busy mid-frame", busy, 1'b1);
    ser_sel = 1'b0;
    @(negedge clk);
    chk_idle("R9");
    @(negedge clk);
    ser_sel = 1'b1;
    run_frame(8'h3C, 1'b1, 1'b1, 0);
    run_frame(8'hC3, 1'b0, 1'b0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule